// File: doc/BRIEF.md
# Playback Sample Unpacker

This block sits between a playback buffer reader and an audio output path. It takes a byte stream and a 16-bit format code. It rebuilds each audio sample from its container bytes and sends it on as a 24-bit signed word, one channel per output beat, tagged with a channel index. The format code is loaded with a one-cycle strobe before a transfer begins. The code chooses:
- the container width: 8, 16, packed 24 or 32 bits;
- the byte order;
- the channel layout: mono duplicated to a pair, mono to a single channel, stereo, or an even multi-channel interleave.

Both sides use valid/ready handshakes. When the consumer stalls, the block stops taking bytes, and no partly assembled sample is lost. Loading a new code clears all assembly and channel state. A code the block cannot serve raises an error flag. While the flag is up, the block accepts incoming bytes and throws them away until a valid code is loaded.

Top module: `pcm_unpacker`

## Requirements
- R1: After reset, and until the first format load, `in_ready`, `out_valid` and `fmt_err` are all 0.
- R2: For codes 0 and 4, each sample is a single unsigned byte. The output is that byte with its top bit inverted, placed in bits 23:16, with bits 15:0 zero.
- R3: For codes 1 and 5, each sample is two bytes, low byte first. The output is {second byte, first byte, 8'h00}.
- R4: For codes 2, 6 and the 0xC0-based codes, each sample is three bytes, least significant byte first. The byte stream 33 22 11 66 55 44 gives 0x112233 and then 0x445566.
- R5: For codes 3, 7 and 8, each sample is four bytes, little-endian, and the output is the top 24 bits {b3,b2,b1}. For codes 9 and 10 the four bytes are big-endian (first byte most significant), and the output is {b0,b1,b2}.
- R6: For codes 0 to 3, each sample is sent twice: first on channel 0, then on channel 1, with the same value both times.
- R7: For codes 8 and 9, each sample is sent once, on channel 0.
- R8: For codes 4 to 7 and 10, samples are sent once each, and the channel index alternates 0, 1, 0, 1 … starting at 0.
- R9: A code with upper byte 0, bits 7:6 equal to 01 (16-bit), 11 (24-bit packed) or 10 (32-bit), and an even factor N from 4 to 16 in bits 5:0, is a little-endian N-channel interleave. Each sample gives one beat, and the channel index counts 0 to N-1 and then wraps.
- R10: Any other code sets `fmt_err`. This includes 0xFF, 11 to 63, odd factors, factors outside 4 to 16, and a nonzero upper byte. While `fmt_err` is set, `in_ready` is 1, accepted bytes produce no output, and the next valid load clears the flag.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_sample` and `out_chan` hold their values. Every accepted byte contributes to exactly one output sample.
- R12: A format load throws away any partly received sample and any pending output, and restarts the channel index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_load | input | 1 | Strobe that loads `fmt_code` and clears stream state |
| fmt_code | input | 16 | Sample format code |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_sample | output | 24 | Signed 24-bit sample, left-justified |
| out_chan | output | 4 | Channel index of the output sample |
| fmt_err | output | 1 | Loaded format code is unsupported |

## Verification
A wrong byte counter or accumulator does not stay hidden. It shifts byte alignment for every later sample in the run, so the very next output beat after the fault shows a wrong value, and the output count at the end is wrong too.

A wrong channel sequencer shows up in `out_chan` within one interleave period. The sweeps therefore run at least two full periods for every interleave factor.

Stall and hold faults appear under the random back-pressure runs. They show as a changed sample during a stall, or as a missing or repeated beat in the collected stream.

// File: rtl/pcm_unpacker_pkg.sv
package pcm_unpacker_pkg;

  localparam int unsigned SMP_W  = 24;
  localparam int unsigned CONT_B = 4;
  localparam int unsigned MAX_CH = 16;
  localparam int unsigned CH_W   = $clog2(MAX_CH);
  localparam int unsigned CNT_W  = $clog2(MAX_CH + 1);
  localparam int unsigned NB_W   = $clog2(CONT_B + 1);

  typedef struct packed {
    logic             ok;
    logic [NB_W-1:0]  nbytes;
    logic             be;
    logic             uns8;
    logic             dup;
    logic [CNT_W-1:0] nchan;
  } fmt_cfg_t;

  function automatic fmt_cfg_t decode_fmt(input logic [15:0] code);
    fmt_cfg_t   c;
    logic [5:0] f;
    c = '0;
    f = code[5:0];
    if (code[15:8] == 8'h00) begin
      if (code[7:0] <= 8'd10) begin
        c.ok = 1'b1;
        if (code[3:0] < 4'd4) begin
          c.nbytes = NB_W'(code[1:0]) + NB_W'(1);
          c.dup    = 1'b1;
          c.nchan  = CNT_W'(2);
        end else if (code[3:0] < 4'd8) begin
          c.nbytes = NB_W'(code[1:0]) + NB_W'(1);
          c.nchan  = CNT_W'(2);
        end else begin
          c.nbytes = NB_W'(4);
          c.be     = (code[3:0] != 4'd8);
          c.nchan  = (code[3:0] == 4'd10) ? CNT_W'(2) : CNT_W'(1);
        end
        c.uns8 = (c.nbytes == NB_W'(1));
      end else if (code[7:6] != 2'b00 && f >= 6'd4 && f <= 6'd16 && !f[0]) begin
        c.ok     = 1'b1;
        c.nchan  = CNT_W'(f);
        unique case (code[7:6])
          2'b01:   c.nbytes = NB_W'(2);
          2'b11:   c.nbytes = NB_W'(3);
          default: c.nbytes = NB_W'(4);
        endcase
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/pcm_fmt_reg.sv
module pcm_fmt_reg
  import pcm_unpacker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt_load,
  input  logic [15:0] fmt_code,
  output fmt_cfg_t    cfg,
  output logic        loaded
);

  fmt_cfg_t cfg_q, cfg_d;
  logic     loaded_q, loaded_d;

  always_comb begin
    cfg_d    = cfg_q;
    loaded_d = loaded_q;
    if (fmt_load) begin
      cfg_d    = decode_fmt(fmt_code);
      loaded_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      loaded_q <= loaded_d;
    end
  end

  assign cfg    = cfg_q;
  assign loaded = loaded_q;

  // R9
  fmt_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.ok |-> (cfg_q.nchan != '0 && cfg_q.nchan <= CNT_W'(MAX_CH)));

endmodule

// File: rtl/pcm_assembler.sv
module pcm_assembler #(
  parameter int unsigned SMP_W  = 24,
  parameter int unsigned CONT_B = 4,
  localparam int unsigned CONT_W = 8 * CONT_B,
  localparam int unsigned NB_W   = $clog2(CONT_B + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [7:0]        byte_in,
  input  logic              ok,
  input  logic [NB_W-1:0]   nbytes,
  input  logic              be,
  input  logic              uns8,
  output logic              complete,
  output logic [SMP_W-1:0]  smp_out
);

  logic [CONT_W-1:0] acc_q, acc_d, full;
  logic [NB_W-1:0]   cnt_q, cnt_d;

  // Little-endian bytes shift in from the top, so a short container ends up
  // left-justified with zero fill and needs no width-dependent alignment.
  always_comb begin
    full     = be ? {acc_q[CONT_W-9:0], byte_in} : {byte_in, acc_q[CONT_W-1:8]};
    complete = (cnt_q == nbytes - NB_W'(1));
    smp_out  = full[CONT_W-1 -: SMP_W] ^ {uns8, {(SMP_W-1){1'b0}}};
  end

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (take) begin
      if (complete) begin
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = full;
        cnt_d = cnt_q + NB_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R4
  byte_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (cnt_q < nbytes));

  // R10
  no_take_when_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |-> (cnt_q == '0));

endmodule

// File: rtl/pcm_emitter.sv
module pcm_emitter #(
  parameter int unsigned SMP_W = 24,
  parameter int unsigned CH_W  = 4,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dup,
  input  logic [CNT_W-1:0] nchan,
  input  logic             load_smp,
  input  logic [SMP_W-1:0] smp_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_sample,
  output logic [CH_W-1:0]  out_chan,
  output logic             slot_free
);

  logic             vld_q, vld_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [CNT_W-1:0] seq_q, seq_d;
  logic             fire, last;

  always_comb begin
    fire      = vld_q & out_ready;
    last      = ~dup | chan_q[0];
    slot_free = ~vld_q | (fire & last);
  end

  always_comb begin
    vld_d  = vld_q;
    smp_d  = smp_q;
    chan_d = chan_q;
    seq_d  = seq_q;
    if (clr) begin
      vld_d  = 1'b0;
      chan_d = '0;
      seq_d  = '0;
    end else if (fire && !last) begin
      chan_d = {{(CH_W-1){1'b0}}, 1'b1};
    end else begin
      if (fire) vld_d = 1'b0;
      if (load_smp) begin
        vld_d = 1'b1;
        smp_d = smp_in;
        if (dup) begin
          chan_d = '0;
        end else begin
          chan_d = seq_q[CH_W-1:0];
          seq_d  = (seq_q == nchan - CNT_W'(1)) ? '0 : seq_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      smp_q  <= '0;
      chan_q <= '0;
      seq_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      smp_q  <= smp_d;
      chan_q <= chan_d;
      seq_q  <= seq_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_sample = smp_q;
  assign out_chan   = chan_q;

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready && !clr) |=> (vld_q && $stable(smp_q) && $stable(chan_q)));

  // R6
  dup_second_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && out_ready && dup && chan_q == '0 && !clr) |=>
      (vld_q && chan_q == {{(CH_W-1){1'b0}}, 1'b1} && $stable(smp_q)));

  // R9
  chan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ({1'b0, chan_q} < {1'b0, nchan}));

  // R11
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_smp |-> slot_free);

endmodule

// File: rtl/pcm_unpacker.sv
module pcm_unpacker
  import pcm_unpacker_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_load,
  input  logic [15:0]      fmt_code,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SMP_W-1:0] out_sample,
  output logic [CH_W-1:0]  out_chan,
  output logic             fmt_err
);

  fmt_cfg_t         cfg;
  logic             loaded;
  logic             complete, slot_free, take;
  logic [SMP_W-1:0] smp_new;

  pcm_fmt_reg u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_load (fmt_load),
    .fmt_code (fmt_code),
    .cfg      (cfg),
    .loaded   (loaded)
  );

  // A byte that does not finish a sample always fits; a finishing byte
  // waits for the output slot. Bad formats swallow bytes.
  always_comb begin
    in_ready = loaded & (~cfg.ok | ~complete | slot_free);
    take     = in_valid & in_ready & cfg.ok;
    fmt_err  = loaded & ~cfg.ok;
  end

  pcm_assembler #(.SMP_W(SMP_W), .CONT_B(CONT_B)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (fmt_load),
    .take     (take),
    .byte_in  (in_data),
    .ok       (cfg.ok),
    .nbytes   (cfg.nbytes),
    .be       (cfg.be),
    .uns8     (cfg.uns8),
    .complete (complete),
    .smp_out  (smp_new)
  );

  pcm_emitter #(.SMP_W(SMP_W), .CH_W(CH_W), .CNT_W(CNT_W)) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fmt_load),
    .dup        (cfg.dup),
    .nchan      (cfg.nchan),
    .load_smp   (take & complete),
    .smp_in     (smp_new),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .out_chan   (out_chan),
    .slot_free  (slot_free)
  );

  // R1
  idle_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (!in_ready && !out_valid && !fmt_err));

  // R10
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> (!out_valid && in_ready));

  // R12
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_load |=> !out_valid);

endmodule

// File: tb/pcm_unpacker_tb.sv
`timescale 1ns/1ps
module pcm_unpacker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_load = 1'b0;
  logic [15:0] fmt_code = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_sample;
  logic [3:0]  out_chan;
  logic        fmt_err;

  always #2 clk = ~clk;

  pcm_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_load(fmt_load), .fmt_code(fmt_code),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
    .out_chan(out_chan), .fmt_err(fmt_err)
  );

  int          checks = 0;
  int          fails  = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  feed[$];
  logic [27:0] expq[$];
  logic [27:0] got[$];

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] code);
    @(negedge clk);
    in_valid = 1'b0;
    fmt_code = code;
    fmt_load = 1'b1;
    @(negedge clk);
    fmt_load = 1'b0;
  endtask

  // Drives feed[] and collects output beats; checks hold during stalls (R11).
  task automatic stream(input bit bp);
    int          fi = 0;
    int          tail = 0;
    int          cyc = 0;
    bit          held = 1'b0;
    logic [27:0] hv = '0;
    got.delete();
    while (cyc < 4000) begin
      @(negedge clk);
      cyc++;
      lfsr = step(lfsr);
      out_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (fi < feed.size()) begin
        in_valid = 1'b1;
        in_data  = feed[fi];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (held && out_valid) chk("R11 stall hold", {4'h0, out_chan, out_sample}, {4'h0, hv});
      held = out_valid && !out_ready;
      hv   = {out_chan, out_sample};
      if (in_valid && in_ready) fi++;
      if (out_valid && out_ready) got.push_back({out_chan, out_sample});
      if (fi == feed.size() && got.size() >= expq.size()) tail++;
      if (tail >= 8) break;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    if (cyc >= 4000) begin
      fails++;
      $display("FAIL R11 stream stuck: actual %0d bytes expected %0d", fi, feed.size());
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " count"}, got.size(), expq.size());
    for (int i = 0; i < expq.size(); i++)
      chk($sformatf("%s item %0d", tag, i), (i < got.size()) ? {4'h0, got[i]} : 32'hxxxxxxxx,
          {4'h0, expq[i]});
  endtask

  // Builds a byte stream of ns samples for a code and the expected beats.
  task automatic build(input logic [15:0] code, input int ns, output string tag);
    int         bps, md, n;
    bit         be;
    logic [7:0] b[4];
    logic [23:0] v;
    be = 1'b0; n = 2;
    if (code <= 16'd10) begin
      if (code < 4)       begin bps = code + 1; md = 0; end
      else if (code < 8)  begin bps = code - 3; md = 2; end
      else begin bps = 4; be = (code != 8); md = (code == 10) ? 2 : 1; end
    end else begin
      md = 3; n = code[5:0];
      bps = (code[7:6] == 2'b01) ? 2 : (code[7:6] == 2'b11) ? 3 : 4;
    end
    tag = $sformatf("code %h %s %s", code,
          (bps == 1) ? "R2" : (bps == 2) ? "R3" : (bps == 3) ? "R4" : "R5",
          (md == 0) ? "R6" : (md == 1) ? "R7" : (md == 2) ? "R8" : "R9");
    feed.delete(); expq.delete();
    for (int k = 0; k < ns; k++) begin
      for (int j = 0; j < bps; j++) begin
        lfsr = step(lfsr);
        b[j] = lfsr[7:0] ^ lfsr[15:8];
        feed.push_back(b[j]);
      end
      case (bps)
        1: v = {b[0] ^ 8'h80, 16'h0};
        2: v = {b[1], b[0], 8'h0};
        3: v = {b[2], b[1], b[0]};
        default: v = be ? {b[0], b[1], b[2]} : {b[3], b[2], b[1]};
      endcase
      case (md)
        0: begin expq.push_back({4'd0, v}); expq.push_back({4'd1, v}); end
        1: expq.push_back({4'd0, v});
        2: expq.push_back({4'(k % 2), v});
        default: expq.push_back({4'(k % n), v});
      endcase
    end
  endtask

  task automatic run_code(input logic [15:0] code, input bit bp);
    string tag;
    int    ns;
    ns = (code > 16'd10) ? 2 * code[5:0] : 6;
    load(code);
    chk("R10 valid code clears error", fmt_err, 0);
    build(code, ns, tag);
    stream(bp);
    compare(bp ? {tag, " R11"} : tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: idle before any load
    chk("R1 in_ready", in_ready, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 fmt_err", fmt_err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 in_ready after release", in_ready, 0);
    chk("R1 fmt_err after release", fmt_err, 0);

    // R4: packed byte order example, duplicated (R6)
    load(16'd2);
    feed = '{8'h33, 8'h22, 8'h11, 8'h66, 8'h55, 8'h44};
    expq = '{{4'd0, 24'h112233}, {4'd1, 24'h112233}, {4'd0, 24'h445566}, {4'd1, 24'h445566}};
    stream(1'b0);
    compare("R4 packed example R6");

    // Base format codes, with and without back-pressure
    for (int c = 0; c <= 10; c++) begin
      run_code(16'(c), 1'b0);
      run_code(16'(c), 1'b1);
    end

    // R9: every interleave factor for each container
    for (int f = 4; f <= 16; f += 2) begin
      run_code(16'h40 | 16'(f), f[1]);
      run_code(16'hC0 | 16'(f), !f[1]);
      run_code(16'h80 | 16'(f), 1'b1);
    end

    // R10: unsupported codes swallow bytes silently
    begin
      logic [15:0] bad[8] = '{16'h000B, 16'h00FF, 16'h0041, 16'h0042,
                              16'h004F, 16'h0052, 16'h0100, 16'h003F};
      for (int i = 0; i < 8; i++) begin
        load(bad[i]);
        #1;
        chk($sformatf("R10 err flag code %h", bad[i]), fmt_err, 1);
        chk($sformatf("R10 in_ready code %h", bad[i]), in_ready, 1);
        feed = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
        expq.delete();
        stream(1'b0);
        compare($sformatf("R10 no output code %h", bad[i]));
        chk("R10 err held", fmt_err, 1);
      end
      run_code(16'd4, 1'b0);
    end

    // R12: reload drops partial sample and restarts channel count
    load(16'h0086);
    feed = '{8'h01, 8'h02, 8'h03, 8'h04, 8'hEE, 8'hDD};
    expq = '{{4'd0, 24'h040302}};
    stream(1'b0);
    compare("R12 before reload");
    run_code(16'h0086, 1'b0);
    load(16'd6);
    feed = '{8'hAA, 8'hBB};
    expq.delete();
    stream(1'b0);
    compare("R12 partial dropped");
    run_code(16'd6, 1'b1);

    finish_run();
  end

endmodule